// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

This block holds two 8-bit up-counting interval timers that share a single free-running prescaler fed by the system clock. Each timer has a run bit, an interrupt enable, a two-bit clock-source code and an 8-bit compare value. On each tick of its selected clock a running timer counts up. When it reaches the last count before the compare value, it wraps to zero on that tick and emits a match. The interrupt output is therefore periodic, with a period of compare value times the tick period.

Timer 0 can count rising edges of an external pin instead of a prescaler tap. Timer 1 can take timer 0's match as its clock, so the two can run as a cascade that gives long intervals. A plain write port sets the control word and the two compare values. Compare values and clock codes are frozen while their timer runs, so software stops a timer before it reconfigures that timer.

Top module: `ivt_dual_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) both timers are stopped, all fields are zero and irq0_o and irq1_o are low.
- R2: A write with wr_en high at a rising edge stores wr_data at wr_addr. Address 0 is the control word: bit 0 run0, bit 1 run1, bits 3:2 timer 0 clock code, bits 5:4 timer 1 clock code, bit 6 interrupt enable 0, bit 7 interrupt enable 1. Address 1 is the timer 0 compare value and address 2 is the timer 1 compare value.
- R3: Timer 0 clock codes are 0 = external pin, 1 = fc/8, 2 = fc/32 and 3 = fc/128. With compare value N, irq0_o pulses every N times the tap period in system clocks.
- R4: Timer 1 clock codes are 0 = timer 0 match, 1 = fc/8, 2 = fc/128 and 3 = fc/2048. With compare value N, irq1_o pulses every N times the tap period.
- R5: A compare value of 0 acts as 256 ticks.
- R6: Each interrupt pulse lasts exactly one system clock. A timer whose enable bit is 0 keeps counting and matching but never raises its interrupt.
- R7: With timer 1 clock code 0, timer 1 advances once per timer 0 match, even when interrupt enable 0 is clear.
- R8: ext_in passes through a two-flip-flop synchronizer. Each synchronized rising edge is one tick for timer 0 clock code 0.
- R9: While a timer runs, writes to its compare value and to its clock code are ignored. Run and enable bits always take effect.
- R10: A stopped timer holds its count at 0 and raises no interrupt. Setting run restarts counting from 0, so the first interrupt comes after a full period of ticks.
- R11: Both timers can run at the same time on independent clock sources, each at its own period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| ext_in | input | 1 | Asynchronous external count input for timer 0 |
| irq0_o | output | 1 | Timer 0 interrupt pulse |
| irq1_o | output | 1 | Timer 1 interrupt pulse |

## Verification
The bench targets the off-by-one points. A timer that compares against the compare value itself instead of one less would show a period one tick too long. A design that failed to map a compare value of 0 to 256 would stall or fire at once. It also rewrites compare values and clock codes in mid-run: a design that honoured those writes would show a shorter or longer period right after the write. The cascade runs with timer 0's interrupt masked, to catch a design that clocks timer 1 from the masked interrupt rather than from the raw match. Stop-and-restart checks that the count returns to zero and that no stale pulse leaks out while the timer is stopped.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the dual interval timer.
// Assumes taps are powers of two of the system clock.
package ivt_pkg;
    localparam int NTAP   = 4;
    localparam int PRE_W  = 11;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP0 = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMP1 = 2'd2;

    typedef logic [1:0] clk_sel_t;

    // Prescaler tap k fires once every 2**tap_shift(k) system clocks.
    function automatic int tap_shift(input int k);
        case (k)
            0:       return 3;
            1:       return 5;
            2:       return 7;
            default: return 11;
        endcase
    endfunction
endpackage

// File: rtl/ivt_prescaler.sv
`timescale 1ns/1ps
// Module: free-running divider that makes one-cycle tick enables.
// Tap 0 = fc/8, tap 1 = fc/32, tap 2 = fc/128, tap 3 = fc/2048.
// Assumes PRE_W covers the largest tap shift.
module ivt_prescaler
    import ivt_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [NTAP-1:0] tap_o
);
    logic [W-1:0] cnt_q;

    // Purpose: advance the divider every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        localparam int SH = tap_shift(k);
        assign tap_o[k] = &cnt_q[SH-1:0];
        if (k > 0) begin : g_nest
            // A slower tap always lines up with the faster one.
            assert_tap_nested_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tap_o[k] |-> tap_o[k-1]);
        end
    end
endmodule

// File: rtl/ivt_edge_sync.sv
`timescale 1ns/1ps
// Module: two-flop synchronizer plus rising-edge detector.
// Assumes din_i is asynchronous; tick_o lasts one clock per rise.
module ivt_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic tick_o
);
    logic [2:0] sh_q;

    // Purpose: shift the pin through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], din_i};
    end

    assign tick_o = sh_q[1] & ~sh_q[2];

    assert_edge_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/ivt_channel.sv
`timescale 1ns/1ps
// Module: one 8-bit interval counter with compare and interrupt.
// Assumes cmp_i only changes while run_i is low; cmp 0 means 256.
// match_o is combinational (same cycle as the wrapping tick);
// irq_o is registered and gated by ie_i.
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [CW-1:0] cmp_i,
    input  logic          ie_i,
    output logic          match_o,
    output logic          irq_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last    = cmp_i - 1'b1;
    assign match_o = run_i & tick_i & (cnt_q == last);

    // Purpose: count ticks while running, wrap on match, hold 0 when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (tick_i)      cnt_q <= match_o ? '0 : cnt_q + 1'b1;
    end

    // Purpose: register the gated match as a one-cycle interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= match_o & ie_i;
    end

    assert_count_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);
    assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    assert_stopped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/ivt_dual_timer.sv
`timescale 1ns/1ps
// Module: two cascadable 8-bit interval timers with a write port.
// Assumes software stops a timer before reconfiguring it; such
// writes are dropped while it runs.
module ivt_dual_timer
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_in,
    output logic              irq0_o,
    output logic              irq1_o
);
    logic              run0_q, run1_q, ie0_q, ie1_q;
    clk_sel_t          sel0_q, sel1_q;
    logic [DATA_W-1:0] cmp0_q, cmp1_q;
    logic [NTAP-1:0]   tap;
    logic              ext_tick, tick0, tick1, match0, match1;

    // Purpose: register writes; clock code and compare frozen while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run0_q <= 1'b0; run1_q <= 1'b0; ie0_q <= 1'b0; ie1_q <= 1'b0;
            sel0_q <= '0;   sel1_q <= '0;   cmp0_q <= '0;  cmp1_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    run0_q <= wr_data[0];
                    run1_q <= wr_data[1];
                    ie0_q  <= wr_data[6];
                    ie1_q  <= wr_data[7];
                    if (!run0_q) sel0_q <= wr_data[3:2];
                    if (!run1_q) sel1_q <= wr_data[5:4];
                end
                A_CMP0: if (!run0_q) cmp0_q <= wr_data;
                A_CMP1: if (!run1_q) cmp1_q <= wr_data;
                default: ;
            endcase
        end
    end

    ivt_prescaler u_pre (.clk(clk), .rst_n(rst_n), .tap_o(tap));
    ivt_edge_sync u_ext (.clk(clk), .rst_n(rst_n), .din_i(ext_in), .tick_o(ext_tick));

    // Purpose: timer 0 clock mux (pin, fc/8, fc/32, fc/128).
    always_comb begin
        case (sel0_q)
            2'd0:    tick0 = ext_tick;
            2'd1:    tick0 = tap[0];
            2'd2:    tick0 = tap[1];
            default: tick0 = tap[2];
        endcase
    end

    // Purpose: timer 1 clock mux (timer 0 match, fc/8, fc/128, fc/2048).
    always_comb begin
        case (sel1_q)
            2'd0:    tick1 = match0;
            2'd1:    tick1 = tap[0];
            2'd2:    tick1 = tap[2];
            default: tick1 = tap[3];
        endcase
    end

    ivt_channel u_t0 (.clk(clk), .rst_n(rst_n), .run_i(run0_q), .tick_i(tick0),
                      .cmp_i(cmp0_q), .ie_i(ie0_q), .match_o(match0), .irq_o(irq0_o));
    ivt_channel u_t1 (.clk(clk), .rst_n(rst_n), .run_i(run1_q), .tick_i(tick1),
                      .cmp_i(cmp1_q), .ie_i(ie1_q), .match_o(match1), .irq_o(irq1_o));

    assert_cmp0_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CMP0 && run0_q) |=> $stable(cmp0_q));
    assert_cmp1_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CMP1 && run1_q) |=> $stable(cmp1_q));
    assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL && run0_q && run1_q) |=> ($stable(sel0_q) && $stable(sel1_q)));
endmodule

// File: tb/ivt_dual_timer_tb.sv
`timescale 1ns/1ps
module ivt_dual_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ext_in = 1'b0;
    logic       irq0_o, irq1_o;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    bit    done = 0, ext_on = 0, cmp_on = 0;
    string cur_req = "R1";
    int    n_irq0 = 0, n_dbl = 0;
    bit    prev0 = 0, prev1 = 0;

    always #2.5 clk = ~clk;

    ivt_dual_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                          .wr_data(wr_data), .ext_in(ext_in), .irq0_o(irq0_o), .irq1_o(irq1_o));

    // Behavioural reference model, advanced on every rising edge.
    int m_pre, m_cnt0, m_cnt1, m_cmp0, m_cmp1, m_sel0, m_sel1;
    bit m_run0, m_run1, m_ie0, m_ie1, m_irq0, m_irq1, m_s1, m_s2, m_s3;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pre = 0; m_cnt0 = 0; m_cnt1 = 0; m_cmp0 = 0; m_cmp1 = 0; m_sel0 = 0; m_sel1 = 0;
            m_run0 = 0; m_run1 = 0; m_ie0 = 0; m_ie1 = 0; m_irq0 = 0; m_irq1 = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            bit t1, t4, t16, t256, et, k0, k1, mt0, mt1, o_run0, o_run1;
            int lim0, lim1;
            t1 = (m_pre % 8) == 7;  t4 = (m_pre % 32) == 31;
            t16 = (m_pre % 128) == 127; t256 = m_pre == 2047;
            et = m_s2 && !m_s3;
            k0 = (m_sel0 == 0) ? et : (m_sel0 == 1) ? t1 : (m_sel0 == 2) ? t4 : t16;
            lim0 = (m_cmp0 == 0) ? 256 : m_cmp0;
            mt0 = m_run0 && k0 && (m_cnt0 == lim0 - 1);
            k1 = (m_sel1 == 0) ? mt0 : (m_sel1 == 1) ? t1 : (m_sel1 == 2) ? t16 : t256;
            lim1 = (m_cmp1 == 0) ? 256 : m_cmp1;
            mt1 = m_run1 && k1 && (m_cnt1 == lim1 - 1);
            m_irq0 = mt0 && m_ie0;
            m_irq1 = mt1 && m_ie1;
            if (!m_run0) m_cnt0 = 0; else if (k0) m_cnt0 = mt0 ? 0 : m_cnt0 + 1;
            if (!m_run1) m_cnt1 = 0; else if (k1) m_cnt1 = mt1 ? 0 : m_cnt1 + 1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
            m_pre = (m_pre + 1) % 2048;
            o_run0 = m_run0; o_run1 = m_run1;
            if (wr_en) begin
                if (wr_addr == 0) begin
                    m_run0 = wr_data[0]; m_run1 = wr_data[1];
                    m_ie0 = wr_data[6]; m_ie1 = wr_data[7];
                    if (!o_run0) m_sel0 = int'(wr_data[3:2]);
                    if (!o_run1) m_sel1 = int'(wr_data[5:4]);
                end else if (wr_addr == 1 && !o_run0) m_cmp0 = int'(wr_data);
                else if (wr_addr == 2 && !o_run1) m_cmp1 = int'(wr_data);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model plus pulse bookkeeping.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(irq0_o == m_irq0, {cur_req, " irq0 vs model"}, int'(irq0_o), int'(m_irq0));
            check(irq1_o == m_irq1, {cur_req, " irq1 vs model"}, int'(irq1_o), int'(m_irq1));
        end
        if (irq0_o) n_irq0++;
        if ((irq0_o && prev0) || (irq1_o && prev1)) n_dbl++;
        prev0 = irq0_o; prev1 = irq1_o;
    end

    // External pin generator: one rise every 6 clocks while enabled.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (ext_on) begin ph = (ph + 1) % 6; ext_in = (ph < 3); end
            else ext_in = 1'b0;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_pulse(input int which);
        do @(negedge clk); while (!((which == 0) ? irq0_o : irq1_o));
    endtask

    task automatic measure(input int which, input int exp, input string req);
        int t_a;
        wait_pulse(which); t_a = cyc;
        wait_pulse(which);
        check((cyc - t_a) == exp, req, cyc - t_a, exp);
    endtask

    task automatic summary();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        repeat (3) @(negedge clk);
        check(irq0_o == 0 && irq1_o == 0, "R1 reset irq", int'(irq0_o) + int'(irq1_o), 0);

        cur_req = "R2/R3";
        wr(2'd1, 8'd40); wr(2'd0, 8'h45);       // fc/8, 40 ticks
        measure(0, 320, "R3 fc/8 cmp 40");
        wr(2'd0, 8'h00);
        wr(2'd1, 8'd3);  wr(2'd0, 8'h49);       // fc/32
        measure(0, 96, "R3 fc/32 cmp 3");
        wr(2'd0, 8'h00);
        wr(2'd1, 8'd2);  wr(2'd0, 8'h4D);       // fc/128
        measure(0, 256, "R3 fc/128 cmp 2");
        wr(2'd0, 8'h00);

        cur_req = "R5";
        wr(2'd1, 8'd0);  wr(2'd0, 8'h45);
        measure(0, 2048, "R5 cmp 0 as 256");
        wr(2'd0, 8'h00);

        cur_req = "R4";
        wr(2'd2, 8'd3);  wr(2'd0, 8'hA2);
        measure(1, 384, "R4 fc/128 cmp 3");
        wr(2'd0, 8'h00);
        wr(2'd2, 8'd2);  wr(2'd0, 8'hB2);
        measure(1, 4096, "R4 fc/2048 cmp 2");
        wr(2'd0, 8'h00);
        wr(2'd2, 8'd5);  wr(2'd0, 8'h92);
        measure(1, 40, "R4 fc/8 cmp 5");
        wr(2'd0, 8'h00);

        cur_req = "R7";
        wr(2'd1, 8'd4); wr(2'd2, 8'd3); wr(2'd0, 8'h87);
        n_irq0 = 0;
        measure(1, 96, "R7 cascade 4x3 fc/8");
        check(n_irq0 == 0, "R6 masked irq0 silent", n_irq0, 0);
        wr(2'd0, 8'h00);

        cur_req = "R11";
        wr(2'd1, 8'd5); wr(2'd2, 8'd3); wr(2'd0, 8'hE7);
        fork
            measure(0, 40, "R11 timer0 alongside");
            measure(1, 384, "R11 timer1 alongside");
        join
        wr(2'd0, 8'h00);

        cur_req = "R8";
        wr(2'd1, 8'd5); wr(2'd0, 8'h41);
        ext_on = 1;
        measure(0, 30, "R8 ext pin 5 rises");
        ext_on = 0;
        wr(2'd0, 8'h00);

        cur_req = "R9";
        wr(2'd1, 8'd10); wr(2'd0, 8'h45);
        wait_pulse(0);
        wr(2'd1, 8'd3); wr(2'd0, 8'h4D);       // both must be ignored
        measure(0, 80, "R9 writes while running ignored");

        cur_req = "R10";
        wr(2'd0, 8'h00);
        n_irq0 = 0;
        repeat (300) @(negedge clk);
        check(n_irq0 == 0, "R10 stopped no irq", n_irq0, 0);
        begin
            int t_s;
            t_s = cyc;
            wr(2'd0, 8'h45);
            wait_pulse(0);
            check((cyc - t_s) >= 72 && (cyc - t_s) <= 92, "R10 restart from 0", cyc - t_s, 80);
        end
        wr(2'd0, 8'h00);
        repeat (20) @(negedge clk);

        check(n_dbl == 0, "R6 one-cycle pulses", n_dbl, 0);
        summary();
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end
endmodule